// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block keeps a calendar alarm setting and checks it against the running time of a separate timekeeper. The setting has four fields: minute, hour, day of month and weekday. Each field carries its own active-low enable in the top bit of its register. When that bit is 1, the field is left out of the comparison. The timekeeper supplies the current BCD time fields and a strobe that pulses for one cycle each time the seconds roll over to 00. The block evaluates the alarm only on that strobe, so the alarm resolves to one minute and seconds are never compared.

A match sets a sticky alarm flag. Software clears the flag by writing 0 to it. While both the flag and the alarm interrupt enable are set, the block drives a registered, level-sensitive interrupt output. All of this state is reached through a byte-wide register port:

| Address | Contents |
|---------|----------|
| 0x00 | Interrupt enable at bit 1 |
| 0x01 | Flag at bit 3 |
| 0x0A | Minute alarm field |
| 0x0B | Hour alarm field |
| 0x0C | Day-of-month alarm field |
| 0x0D | Weekday alarm field |

Top module: `cal_alarm_match`

## Requirements
- R1: After reset, every alarm register reads 0x80 (field disabled, value 0). The flag, the interrupt enable and the interrupt output are all 0.
- R2: Each alarm register stores bit 7 as its disable bit plus a value of 7 bits (minute), 6 bits (hour), 6 bits (day of month) or 3 bits (weekday). Value bits above the field width read back as 0. Read data appears one cycle after the address is presented. Address 0x00 reads the enable at bit 1 and address 0x01 reads the flag at bit 3; all other bits of these two addresses read 0.
- R3: On a rollover strobe, the flag sets if at least one field is enabled and every enabled field equals the corresponding current time field. The flag is visible after the clock edge that samples the strobe.
- R4: A field whose bit 7 is 1 has no effect on the match, whatever its value.
- R5: If all four fields are disabled, a strobe never sets the flag.
- R6: Once set, the flag stays set. Writing 0 to bit 3 of address 0x01 clears it. Writing 1 to that bit leaves the flag unchanged.
- R7: A match in the same cycle as a clear write leaves the flag set.
- R8: The interrupt output equals (enable AND flag) delayed by one register stage. It falls in the cycle after the flag is cleared or the enable is removed.
- R9: Matching time inputs without a strobe never set the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 6 | Current hours, BCD |
| cur_mday | input | 6 | Current day of month, BCD |
| cur_wday | input | 3 | Current weekday |
| min_tick | input | 1 | One-cycle strobe when seconds roll to 00 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 5 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data for the previous cycle's address |
| alarm_irq | output | 1 | Level interrupt, enable AND flag |

## Verification
The main sweep programs a fixed alarm and walks through all 16 combinations of enabled fields. For each combination it applies all 16 patterns of which current-time fields differ by one from the alarm. This separates a correct enable mask from a missing one, from an inverted one and from one that looks at the wrong field, and it covers the all-disabled case. Separate sequences cover the following:
- matching time presented without a strobe;
- writing 1 to the flag;
- a clear write landing in the same cycle as a match;
- the exact cycle in which the interrupt falls after either of its two conditions is removed;
- readback truncation of values wider than each field.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD   = 4;
  localparam int VAL_W    = 7;
  localparam int ADDR_CE  = 0;   // enable register
  localparam int ADDR_CF  = 1;   // flag register
  localparam int ADDR_ALM = 10;  // first alarm field register
  localparam int IE_BIT   = 1;
  localparam int FLAG_BIT = 3;

  typedef struct packed {
    logic             off;  // 1 = field excluded
    logic [VAL_W-1:0] val;
  } alm_field_t;
endpackage

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
  import cal_alarm_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst,
  input  alm_field_t [NFIELD-1:0] alm,
  input  logic [NFIELD-1:0][VAL_W-1:0] cur,
  input  logic                  tick,
  output logic                  hit
);
  logic [NFIELD-1:0] eq;
  logic [NFIELD-1:0] off_v;

  genvar gi;
  generate
    for (gi = 0; gi < NFIELD; gi++) begin : g_fld
      assign off_v[gi] = alm[gi].off;
      assign eq[gi]    = alm[gi].off | (alm[gi].val == cur[gi]);
    end
  endgenerate

  assign hit = tick & ~(&off_v) & (&eq);

  // R5
  all_off_chk: assert property (@(posedge clk) disable iff (rst)
    (&off_v) |-> !hit);
endmodule

// File: rtl/cal_alarm_regs.sv
module cal_alarm_regs
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int MDAY_W = 6,
  parameter int WDAY_W = 3
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       addr,
  input  logic [7:0]              wdata,
  input  logic                    ie,
  input  logic                    flag,
  output alm_field_t [NFIELD-1:0] alm,
  output logic [7:0]              rdata
);
  localparam int FW [NFIELD] = '{MIN_W, HOUR_W, MDAY_W, WDAY_W};

  genvar gi;
  generate
    for (gi = 0; gi < NFIELD; gi++) begin : g_reg
      localparam logic [7:0] VMASK = 8'((9'd1 << FW[gi]) - 9'd1);
      localparam logic [ADDR_W-1:0] MY_ADDR = ADDR_W'(ADDR_ALM + gi);
      always_ff @(posedge clk) begin
        if (rst) begin
          alm[gi].off <= 1'b1;
          alm[gi].val <= '0;
        end else if (we && addr == MY_ADDR) begin
          alm[gi].off <= wdata[7];
          alm[gi].val <= wdata[VAL_W-1:0] & VMASK[VAL_W-1:0];
        end
      end
    end
  endgenerate

  logic [ADDR_W-1:0] rel;
  assign rel = addr - ADDR_W'(ADDR_ALM);

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (addr == ADDR_W'(ADDR_CE)) begin
      rdata <= 8'(ie) << IE_BIT;
    end else if (addr == ADDR_W'(ADDR_CF)) begin
      rdata <= 8'(flag) << FLAG_BIT;
    end else if (addr >= ADDR_W'(ADDR_ALM) && rel < ADDR_W'(NFIELD)) begin
      rdata <= alm[rel[1:0]];
    end else begin
      rdata <= '0;
    end
  end
endmodule

// File: rtl/cal_alarm_ctrl.sv
module cal_alarm_ctrl
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  input  logic              hit,
  output logic              ie,
  output logic              flag,
  output logic              irq
);
  logic clr_wr;
  assign clr_wr = we && addr == ADDR_W'(ADDR_CF) && !wdata[FLAG_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ie   <= 1'b0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (we && addr == ADDR_W'(ADDR_CE)) ie <= wdata[IE_BIT];
      if (hit)         flag <= 1'b1;
      else if (clr_wr) flag <= 1'b0;
      irq <= ie & flag;
    end
  end

  // R6
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    (flag && !clr_wr) |=> flag);
  // R7
  hit_wins_chk: assert property (@(posedge clk) disable iff (rst)
    hit |=> flag);
  // R8
  irq_drop_chk: assert property (@(posedge clk) disable iff (rst)
    (!ie || !flag) |=> !irq);
  // R9
  flag_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(flag) |-> $past(hit));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
  import cal_alarm_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int MIN_W  = 7,
  parameter int HOUR_W = 6,
  parameter int MDAY_W = 6,
  parameter int WDAY_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [MIN_W-1:0]  cur_min,
  input  logic [HOUR_W-1:0] cur_hour,
  input  logic [MDAY_W-1:0] cur_mday,
  input  logic [WDAY_W-1:0] cur_wday,
  input  logic              min_tick,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              alarm_irq
);
  alm_field_t [NFIELD-1:0]          alm;
  logic [NFIELD-1:0][VAL_W-1:0]     cur;
  logic                             hit, ie, flag;

  assign cur[0] = VAL_W'(cur_min);
  assign cur[1] = VAL_W'(cur_hour);
  assign cur[2] = VAL_W'(cur_mday);
  assign cur[3] = VAL_W'(cur_wday);

  cal_alarm_regs #(.ADDR_W(ADDR_W), .MIN_W(MIN_W), .HOUR_W(HOUR_W),
                   .MDAY_W(MDAY_W), .WDAY_W(WDAY_W)) u_regs (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .ie(ie), .flag(flag), .alm(alm), .rdata(reg_rdata));

  cal_alarm_cmp u_cmp (
    .clk(clk), .rst(rst), .alm(alm), .cur(cur), .tick(min_tick), .hit(hit));

  cal_alarm_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
    .hit(hit), .ie(ie), .flag(flag), .irq(alarm_irq));
endmodule

// File: tb/test_cal_alarm_match.sv
module test_cal_alarm_match;
  logic clk = 0, rst = 1;
  logic [6:0] cur_min = 0;
  logic [5:0] cur_hour = 0, cur_mday = 0;
  logic [2:0] cur_wday = 0;
  logic min_tick = 0, reg_we = 0;
  logic [4:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic alarm_irq;
  int total = 0, bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cal_alarm_match i_cal_alarm_match (.*);

  localparam logic [7:0] AV [4] = '{8'h45, 8'h13, 8'h21, 8'h05};

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [7:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0;
  endtask

  task automatic rd(logic [4:0] a, output logic [7:0] d);
    @(negedge clk); reg_addr = a;
    @(negedge clk); d = reg_rdata;
  endtask

  task automatic tick_once();
    @(negedge clk); min_tick = 1;
    @(negedge clk); min_tick = 0;
  endtask

  task automatic set_time(logic [3:0] diff);
    cur_min  = 7'(AV[0]) ^ 7'(diff[0]);
    cur_hour = 6'(AV[1]) ^ 6'(diff[1]);
    cur_mday = 6'(AV[2]) ^ 6'(diff[2]);
    cur_wday = 3'(AV[3]) ^ 3'(diff[3]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk); rst = 0;
    // R1 reset state
    for (int i = 0; i < 4; i++) begin rd(5'(10 + i), d); check("R1 alarm reset", d, 8'h80); end
    rd(5'd0, d); check("R1 enable reset", d, 8'h00);
    rd(5'd1, d); check("R1 flag reset", d, 8'h00);
    check("R1 irq reset", 8'(alarm_irq), 8'h00);
    // R2 field widths
    for (int i = 0; i < 4; i++) wr(5'(10 + i), 8'hFF);
    rd(5'd10, d); check("R2 minute width", d, 8'hFF);
    rd(5'd11, d); check("R2 hour width", d, 8'hBF);
    rd(5'd12, d); check("R2 mday width", d, 8'hBF);
    rd(5'd13, d); check("R2 wday width", d, 8'h87);
    wr(5'd0, 8'hFF); rd(5'd0, d); check("R2 enable readback", d, 8'h02);
    // R3 R4 R5 sweep: m bit=1 field enabled; d bit=1 field differs
    for (int m = 0; m < 16; m++) begin
      for (int i = 0; i < 4; i++) wr(5'(10 + i), {~m[i], AV[i][6:0]});
      for (int df = 0; df < 16; df++) begin
        logic exp;
        exp = (m != 0) && ((m & df) == 0);
        set_time(4'(df));
        tick_once();
        rd(5'd1, d);
        check(m == 0 ? "R5 all disabled" : "R3 R4 masked match", d, exp ? 8'h08 : 8'h00);
        check("R8 irq level", 8'(alarm_irq), 8'(exp));
        wr(5'd1, 8'h00);
        @(negedge clk);
      end
    end
    // R9 match without strobe
    for (int i = 0; i < 4; i++) wr(5'(10 + i), {1'b0, AV[i][6:0]});
    set_time(4'd0);
    repeat (5) @(negedge clk);
    rd(5'd1, d); check("R9 no strobe", d, 8'h00);
    // R6 sticky; write 1 no effect
    tick_once();
    set_time(4'hF);
    wr(5'd1, 8'hFF);
    rd(5'd1, d); check("R6 write one keeps flag", d, 8'h08);
    tick_once(); // non-matching strobe
    rd(5'd1, d); check("R6 sticky after mismatch", d, 8'h08);
    // R8 irq falls the cycle after enable removal
    wr(5'd0, 8'h00);
    check("R8 irq still high", 8'(alarm_irq), 8'h01);
    @(negedge clk); check("R8 irq fell after disable", 8'(alarm_irq), 8'h00);
    wr(5'd0, 8'h02);
    @(negedge clk); check("R8 irq back", 8'(alarm_irq), 8'h01);
    // R6 clear; R8 irq falls one cycle later
    wr(5'd1, 8'h00);
    check("R8 irq before drop", 8'(alarm_irq), 8'h01);
    @(negedge clk); check("R8 irq fell after clear", 8'(alarm_irq), 8'h00);
    rd(5'd1, d); check("R6 cleared", d, 8'h00);
    // R7 match and clear in same cycle
    set_time(4'd0);
    @(negedge clk); min_tick = 1; reg_we = 1; reg_addr = 5'd1; reg_wdata = 8'h00;
    @(negedge clk); min_tick = 0; reg_we = 0;
    rd(5'd1, d); check("R7 match beats clear", d, 8'h08);
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule